// File: doc/BRIEF.md
# Two-Thread Tournament Branch Direction Predictor

This block guesses whether a conditional branch is taken. It serves two hardware threads from three shared tables of 2-bit saturating counters. The first table is indexed by the branch address alone. The second is indexed by the address mixed with the requesting thread's recent branch history. The third, a selector table indexed by address, decides which of the first two gives the final answer. Each thread keeps its own history register. On every lookup the history is advanced with the predicted direction. When a branch resolves and the final guess turns out wrong, the history is repaired.

A fetch unit presents one lookup per cycle: an address and a thread number. One cycle later it receives the final prediction, both component predictions and the history that was used. When the branch resolves, the back end returns these values on the update port together with the real outcome. All three counter tables are then trained from that update.

The tables are single-write block memories with synchronous reads. After reset the block clears them one entry per cycle and raises `ready` when the clearing is complete.

Top module: `tourney_pred`

## Requirements
- R1: After a synchronous reset, `ready` stays low for exactly 2^IDX_W clock edges and then stays high. While it is low, lookups and updates are ignored and `pr_valid` stays 0. When `ready` rises, every counter in all three tables holds 1 and both thread histories are 0.
- R2: While `ready` is high, a lookup can be accepted on every cycle, for either thread and in any order. For a lookup accepted on one edge, `pr_valid` is 1 with its results after the next edge. A cycle without an accepted lookup gives `pr_valid` 0 on the following cycle.
- R3: The address index of a PC is the XOR of its IDX_W-bit slices. With the defaults this is pc[7:0] ^ pc[15:8]. `pr_bim` is bit 1 of the address-indexed counter at that index.
- R4: The path-correlated index is the address index XOR'd with the thread's history. The history is zero-extended to IDX_W bits. `pr_path` is bit 1 of that counter.
- R5: The selector counter sits at the address index. `pr_taken` equals `pr_path` when the selector counter is 2 or 3, and equals `pr_bim` otherwise.
- R6: Every accepted update trains both component counters toward `up_taken`. The address counter uses the address index of `up_pc`. The path counter uses the address index of `up_pc` XOR `up_hist`. Each step is +1 for taken and -1 for not taken, saturating at 0 and 3.
- R7: The selector counter at the address index of `up_pc` changes only when `up_bim` differs from `up_path`. It then steps +1 if `up_path` equals `up_taken` and -1 otherwise, saturating at 0 and 3.
- R8: Histories are shifted left, with the newest direction in bit 0. Each accepted lookup shifts its prediction into its thread's history. A lookup from the same thread on the very next cycle already uses the shifted value. `pr_hist` reports the history that was used.
- R9: An accepted update whose `up_taken` differs from `up_pred` sets that thread's history to {up_hist[HIST_W-2:0], up_taken}. The repaired history is used by lookups from the following cycle on. A lookup of the same thread accepted in the same cycle as the repair has its prediction shifted in on top of the repaired value. The other thread's history is not changed.
- R10: Counter changes from an update accepted on one edge are seen by lookups accepted two or more edges later. Back-to-back updates that hit the same counter both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | Table clearing finished; requests accepted |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_W | Branch address of the lookup |
| lk_tid | input | TID_W | Thread of the lookup |
| pr_valid | output | 1 | Prediction outputs valid (one cycle after the lookup) |
| pr_taken | output | 1 | Final predicted direction |
| pr_bim | output | 1 | Address-indexed component prediction |
| pr_path | output | 1 | History-indexed component prediction |
| pr_hist | output | HIST_W | History used for this lookup |
| up_valid | input | 1 | Resolved-branch update |
| up_pc | input | PC_W | Branch address being resolved |
| up_tid | input | TID_W | Thread of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_pred | input | 1 | Final prediction made at lookup |
| up_bim | input | 1 | Address-indexed component prediction made at lookup |
| up_path | input | 1 | History-indexed component prediction made at lookup |
| up_hist | input | HIST_W | History reported with the lookup |

## Verification
The bench goes after a lookup that follows a same-thread lookup on the very next cycle. A design that skips the history bypass would index the path table with a stale history and report a `pr_hist` that lags one branch. It also hits two updates in a row that fall on the same counter: without forwarding, the second write would overwrite the first and the counter would move one step instead of two. A mispredict repair is made to coincide with a lookup of the same thread and of the other thread. A wrong priority between repair and speculative shift, or a repair applied to both threads, then shows up in `pr_hist` and in the path prediction. Counters are driven past both ends of their range, updates are sent with agreeing and disagreeing component guesses to catch a selector that trains when it should not, and lookups and updates are sent while the tables are still being cleared.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Value every counter takes when the tables are cleared.
  localparam logic [1:0] CTR_CLEAR = 2'b01;

  // Number of tables and their slots in the bank arrays.
  localparam int NTAB    = 3;
  localparam int TAB_BIM = 0;
  localparam int TAB_PTH = 1;
  localparam int TAB_SEL = 2;

  // One step of a 2-bit saturating counter.
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

endpackage

// File: rtl/tp_ctr_bank.sv
// One table of 2-bit counters: a synchronous lookup read, a synchronous
// read for update, and a single write port.
// An update reads its counter on one edge and writes it on the next. The old
// value seen by the write stage is forwarded from the write made one edge
// earlier, so back-to-back updates to one entry accumulate.
module tp_ctr_bank import tp_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             init_en,
  input  logic [IDX_W-1:0] init_idx,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [1:0]       lk_ctr,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       old_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] mem [DEPTH];
  logic [1:0] lk_q;
  logic [1:0] rd_q;
  logic [1:0] fwd_val;
  logic       fwd_hit;

  always_ff @(posedge clk) begin
    if (init_en)     mem[init_idx] <= CTR_CLEAR;
    else if (wr_en)  mem[wr_idx]   <= wr_ctr;
  end

  always_ff @(posedge clk) begin
    if (lk_en) lk_q <= mem[lk_idx];
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q    <= mem[rd_idx];
      fwd_hit <= wr_en && !init_en && (wr_idx == rd_idx);
      fwd_val <= wr_ctr;
    end
  end

  assign lk_ctr  = lk_q;
  assign old_ctr = fwd_hit ? fwd_val : rd_q;

endmodule

// File: rtl/tp_hist.sv
// Per-thread history registers. The prediction of a lookup is shifted in one
// edge after the lookup, and is bypassed to a same-thread lookup in that
// cycle. A repair from a mispredicted update takes priority over the shift.
module tp_hist #(
  parameter int HIST_W = 8,
  parameter int NTHR   = 2,
  parameter int TID_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TID_W-1:0]  lk_tid,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              pend_v,
  input  logic [TID_W-1:0]  pend_tid,
  input  logic              pend_dir,
  input  logic              fix_v,
  input  logic [TID_W-1:0]  fix_tid,
  input  logic [HIST_W-1:0] fix_hist
);
  logic [HIST_W-1:0] hist_q [NTHR];
  logic [HIST_W-1:0] sel_h;

  always_ff @(posedge clk) begin
    for (int t = 0; t < NTHR; t++) begin
      if (rst)
        hist_q[t] <= '0;
      else if (fix_v && fix_tid == TID_W'(t))
        hist_q[t] <= fix_hist;
      else if (pend_v && pend_tid == TID_W'(t))
        hist_q[t] <= {hist_q[t][HIST_W-2:0], pend_dir};
    end
  end

  assign sel_h   = hist_q[lk_tid];
  assign lk_hist = (pend_v && pend_tid == lk_tid) ? {sel_h[HIST_W-2:0], pend_dir} : sel_h;

endmodule

// File: rtl/tourney_pred.sv
// Two-thread tournament direction predictor: an address-indexed table, a
// history-indexed table and an address-indexed selector, all shared.
// Requires HIST_W <= IDX_W <= PC_W and HIST_W >= 2.
module tourney_pred import tp_pkg::*; #(
  parameter int PC_W   = 16,
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8,
  parameter int NTHR   = 2,
  parameter int TID_W  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ready,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [TID_W-1:0]  lk_tid,
  output logic              pr_valid,
  output logic              pr_taken,
  output logic              pr_bim,
  output logic              pr_path,
  output logic [HIST_W-1:0] pr_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [TID_W-1:0]  up_tid,
  input  logic              up_taken,
  input  logic              up_pred,
  input  logic              up_bim,
  input  logic              up_path,
  input  logic [HIST_W-1:0] up_hist
);
  localparam int NSLICE = (PC_W + IDX_W - 1) / IDX_W;

  // XOR of the IDX_W-bit slices of an address.
  function automatic logic [IDX_W-1:0] pc_index(input logic [PC_W-1:0] pc);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = 0; k < NSLICE; k++) r ^= IDX_W'(pc >> (k * IDX_W));
    return r;
  endfunction

  // ---------------- table clearing after reset ----------------
  logic [IDX_W-1:0] init_idx;
  logic             ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_idx <= '0;
      ready_q  <= 1'b0;
    end else if (!ready_q) begin
      init_idx <= init_idx + IDX_W'(1);
      if (&init_idx) ready_q <= 1'b1;
    end
  end

  logic lk_fire, up_fire;
  assign lk_fire = lk_valid & ready_q;
  assign up_fire = up_valid & ready_q;

  // ---------------- lookup side ----------------
  logic [HIST_W-1:0] lk_hist;
  logic [IDX_W-1:0]  lk_aidx, lk_pidx;
  logic              pv_q;
  logic [TID_W-1:0]  ptid_q;
  logic [HIST_W-1:0] phist_q;
  logic              pred;

  assign lk_aidx = pc_index(lk_pc);
  assign lk_pidx = lk_aidx ^ IDX_W'(lk_hist);

  always_ff @(posedge clk) begin
    if (rst) pv_q <= 1'b0;
    else     pv_q <= lk_fire;
  end

  always_ff @(posedge clk) begin
    if (lk_fire) begin
      ptid_q  <= lk_tid;
      phist_q <= lk_hist;
    end
  end

  // ---------------- update side ----------------
  logic [IDX_W-1:0] up_aidx, up_pidx;
  logic             u_v, u_taken, u_sel_en, u_sel_up;
  logic [IDX_W-1:0] u_aidx, u_pidx;
  logic             fix_v;
  logic [HIST_W-1:0] fix_hist;

  assign up_aidx  = pc_index(up_pc);
  assign up_pidx  = up_aidx ^ IDX_W'(up_hist);
  assign fix_v    = up_fire & (up_taken ^ up_pred);
  assign fix_hist = {up_hist[HIST_W-2:0], up_taken};

  always_ff @(posedge clk) begin
    if (rst) u_v <= 1'b0;
    else     u_v <= up_fire;
  end

  always_ff @(posedge clk) begin
    if (up_fire) begin
      u_aidx   <= up_aidx;
      u_pidx   <= up_pidx;
      u_taken  <= up_taken;
      u_sel_en <= up_bim ^ up_path;
      u_sel_up <= (up_path == up_taken);
    end
  end

  // ---------------- history registers ----------------
  tp_hist #(.HIST_W(HIST_W), .NTHR(NTHR), .TID_W(TID_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .lk_tid   (lk_tid),
    .lk_hist  (lk_hist),
    .pend_v   (pv_q),
    .pend_tid (ptid_q),
    .pend_dir (pred),
    .fix_v    (fix_v),
    .fix_tid  (up_tid),
    .fix_hist (fix_hist)
  );

  // ---------------- the three counter tables ----------------
  logic [IDX_W-1:0] lk_idx_a [NTAB];
  logic [IDX_W-1:0] rd_idx_a [NTAB];
  logic [IDX_W-1:0] wr_idx_a [NTAB];
  logic [1:0]       lk_ctr_a [NTAB];
  logic [1:0]       old_a    [NTAB];
  logic [1:0]       wr_ctr_a [NTAB];
  logic             wr_en_a  [NTAB];

  for (genvar g = 0; g < NTAB; g++) begin : g_tab
    if (g == TAB_PTH) begin : g_path
      assign lk_idx_a[g] = lk_pidx;
      assign rd_idx_a[g] = up_pidx;
      assign wr_idx_a[g] = u_pidx;
    end else begin : g_addr
      assign lk_idx_a[g] = lk_aidx;
      assign rd_idx_a[g] = up_aidx;
      assign wr_idx_a[g] = u_aidx;
    end

    if (g == TAB_SEL) begin : g_sel
      assign wr_en_a[g]  = u_v & u_sel_en;
      assign wr_ctr_a[g] = ctr_step(old_a[g], u_sel_up);
    end else begin : g_dir
      assign wr_en_a[g]  = u_v;
      assign wr_ctr_a[g] = ctr_step(old_a[g], u_taken);
    end

    tp_ctr_bank #(.IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .init_en  (!ready_q),
      .init_idx (init_idx),
      .lk_en    (lk_fire),
      .lk_idx   (lk_idx_a[g]),
      .lk_ctr   (lk_ctr_a[g]),
      .rd_en    (up_fire),
      .rd_idx   (rd_idx_a[g]),
      .old_ctr  (old_a[g]),
      .wr_en    (wr_en_a[g]),
      .wr_idx   (wr_idx_a[g]),
      .wr_ctr   (wr_ctr_a[g])
    );
  end

  assign pred = lk_ctr_a[TAB_SEL][1] ? lk_ctr_a[TAB_PTH][1] : lk_ctr_a[TAB_BIM][1];

  assign ready    = ready_q;
  assign pr_valid = pv_q;
  assign pr_taken = pred;
  assign pr_bim   = lk_ctr_a[TAB_BIM][1];
  assign pr_path  = lk_ctr_a[TAB_PTH][1];
  assign pr_hist  = phist_q;

endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
  parameter int HIST_W = 8,
  parameter int TID_W  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              lk_valid,
  input logic [TID_W-1:0]  lk_tid,
  input logic              pr_valid,
  input logic              pr_taken,
  input logic              pr_bim,
  input logic              pr_path,
  input logic [HIST_W-1:0] pr_hist,
  input logic              up_valid,
  input logic [TID_W-1:0]  up_tid,
  input logic              up_taken,
  input logic              up_pred
);

  AST_INIT_SILENT: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !pr_valid); // R1

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R1

  AST_LOOKUP_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && ready) |=> pr_valid); // R2

  AST_NO_SPURIOUS_PRED: assert property (@(posedge clk) disable iff (rst)
    !(lk_valid && ready) |=> !pr_valid); // R2

  AST_FINAL_FROM_COMPONENT: assert property (@(posedge clk) disable iff (rst)
    pr_valid |-> (pr_taken == pr_bim || pr_taken == pr_path)); // R5

  AST_HIST_CHAINS: assert property (@(posedge clk) disable iff (rst)
    (pr_valid && $past(pr_valid) && $past(lk_tid) == $past(lk_tid, 2) &&
     !($past(up_valid, 2) && $past(up_tid, 2) == $past(lk_tid, 2) &&
       $past(up_taken, 2) != $past(up_pred, 2)))
    |-> pr_hist == {$past(pr_hist[HIST_W-2:0]), $past(pr_taken)}); // R8

endmodule

bind tourney_pred tp_chk #(.HIST_W(HIST_W), .TID_W(TID_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ready    (ready),
  .lk_valid (lk_valid),
  .lk_tid   (lk_tid),
  .pr_valid (pr_valid),
  .pr_taken (pr_taken),
  .pr_bim   (pr_bim),
  .pr_path  (pr_path),
  .pr_hist  (pr_hist),
  .up_valid (up_valid),
  .up_tid   (up_tid),
  .up_taken (up_taken),
  .up_pred  (up_pred)
);

// File: tb/tourney_pred_tb.sv
`timescale 1ns/1ps
module tourney_pred_tb;
  localparam int PC_W = 16, IDX_W = 8, HIST_W = 8, NTHR = 2, TID_W = 1;
  localparam int DEPTH = 256;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic ready, lk_valid, pr_valid, pr_taken, pr_bim, pr_path;
  logic [PC_W-1:0] lk_pc, up_pc;
  logic [TID_W-1:0] lk_tid, up_tid;
  logic [HIST_W-1:0] pr_hist, up_hist;
  logic up_valid, up_taken, up_pred, up_bim, up_path;

  tourney_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .NTHR(NTHR)) u_dut (
    .clk(clk), .rst(rst), .ready(ready),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_tid(lk_tid),
    .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_bim(pr_bim), .pr_path(pr_path), .pr_hist(pr_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_tid(up_tid), .up_taken(up_taken),
    .up_pred(up_pred), .up_bim(up_bim), .up_path(up_path), .up_hist(up_hist));

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference ----------------
  int mb[DEPTH], mp[DEPTH], mc[DEPTH];
  int mh[NTHR];
  int cnt;
  bit mrdy;
  bit pu_v; int pu_a, pu_p; bit pu_t, pu_sen, pu_sup;
  bit e_v, e_t, e_b, e_p; int e_h, e_pc, e_tid;
  int ai, pi, th;

  typedef struct { int pc; int tid; int hist; bit pb; bit pp; bit pt; } rec_t;
  rec_t q[$];

  function automatic int aidx(int pc);
    return (pc ^ (pc >> 8)) & 255;
  endfunction

  function automatic int step(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin mb[i] = 1; mp[i] = 1; mc[i] = 1; end
      for (int t = 0; t < NTHR; t++) mh[t] = 0;
      cnt = 0; mrdy = 0; pu_v = 0; e_v = 0;
    end else if (!mrdy) begin
      cnt++;
      if (cnt == DEPTH) mrdy = 1;
      e_v = 0;
    end else begin
      e_v = lk_valid;
      if (lk_valid) begin
        th = int'(lk_tid);
        ai = aidx(int'(lk_pc));
        pi = (ai ^ mh[th]) & 255;
        e_b = mb[ai] >= 2; e_p = mp[pi] >= 2;
        e_t = (mc[ai] >= 2) ? e_p : e_b;
        e_h = mh[th]; e_pc = int'(lk_pc); e_tid = th;
      end
      if (pu_v) begin
        mb[pu_a] = step(mb[pu_a], pu_t);
        mp[pu_p] = step(mp[pu_p], pu_t);
        if (pu_sen) mc[pu_a] = step(mc[pu_a], pu_sup);
      end
      pu_v = up_valid;
      if (up_valid) begin
        pu_a = aidx(int'(up_pc));
        pu_p = (pu_a ^ int'(up_hist)) & 255;
        pu_t = up_taken; pu_sen = (up_bim != up_path); pu_sup = (up_path == up_taken);
        if (up_taken != up_pred) mh[int'(up_tid)] = ((int'(up_hist) << 1) | int'(up_taken)) & 255;
      end
      if (lk_valid) mh[th] = ((mh[th] << 1) | int'(e_t)) & 255;
    end
  end

  // ---------------- checking and stimulus helpers ----------------
  task automatic chk();
    checks++;
    if (ready !== mrdy || pr_valid !== e_v ||
        (e_v && (pr_taken !== e_t || pr_bim !== e_b || pr_path !== e_p || pr_hist !== HIST_W'(e_h)))) begin
      fails++;
      $display("FAIL %s: rdy/v/t/b/p/h actual %0d %0d %0d %0d %0d %0h expected %0d %0d %0d %0d %0d %0h",
               cur_req, ready, pr_valid, pr_taken, pr_bim, pr_path, pr_hist,
               mrdy, e_v, e_t, e_b, e_p, e_h);
    end
    if (e_v) q.push_back('{e_pc, e_tid, e_h, e_b, e_p, e_t});
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk();
  endtask

  task automatic idle();
    lk_valid = 0; up_valid = 0;
  endtask

  task automatic look(input int pc, input int tid);
    lk_valid = 1; lk_pc = PC_W'(pc); lk_tid = TID_W'(tid);
  endtask

  task automatic resolve(input bit taken);
    rec_t r;
    if (q.size() == 0) begin up_valid = 0; return; end
    r = q.pop_front();
    up_valid = 1; up_pc = PC_W'(r.pc); up_tid = TID_W'(r.tid); up_hist = HIST_W'(r.hist);
    up_taken = taken; up_pred = r.pt; up_bim = r.pb; up_path = r.pp;
  endtask

  task automatic resolve_flip();
    if (q.size() == 0) begin up_valid = 0; return; end
    resolve(!q[0].pt);
  endtask

  task automatic train(input int pc, input int tid, input bit taken, input int n);
    for (int i = 0; i < n; i++) begin
      look(pc, tid); up_valid = 0; cyc();
      idle(); resolve(taken); cyc();
      idle(); cyc();
    end
  endtask

  int pool[6] = '{32'h0012, 32'h1200, 32'h0034, 32'h3401, 32'h00a7, 32'h5555};

  initial begin
    idle(); lk_pc = '0; lk_tid = '0; up_pc = '0; up_tid = '0; up_hist = '0;
    up_taken = 0; up_pred = 0; up_bim = 0; up_path = 0;
    repeat (3) cyc();
    @(negedge clk); rst = 0;

    // R1: requests during clearing are ignored, ready timing checked
    cur_req = "R1";
    while (!mrdy) begin
      look(16'h0012, 1); up_valid = 1; up_pc = 16'h0012; up_taken = 1; up_pred = 0;
      up_bim = 0; up_path = 1; up_hist = 8'hff;
      cyc();
    end
    idle(); q.delete(); cyc();
    for (int i = 0; i < 6; i++) begin look(pool[i], i % 2); cyc(); end
    idle(); cyc();

    // R3 and R6: counters trained up to saturation and back down
    cur_req = "R6"; q.delete();
    train(16'h0012, 0, 1, 5);
    train(16'h0012, 0, 0, 5);
    cur_req = "R3";
    train(16'h1200, 0, 1, 3);
    look(16'h0012, 1); cyc(); idle(); cyc();

    // R4: same address, different histories per thread
    cur_req = "R4"; q.delete();
    train(16'h0034, 1, 1, 4);
    train(16'h0034, 0, 0, 2);
    look(16'h0034, 1); cyc(); look(16'h0034, 0); cyc(); idle(); cyc();

    // R5 and R7: disagreement between components trains the selector
    cur_req = "R7"; q.delete();
    for (int i = 0; i < 12; i++) train(16'h00a7, i % 2, (i % 3) != 0, 1);
    cur_req = "R5";
    for (int i = 0; i < 8; i++) train(16'h00a7, 0, 1, 1);

    // R8: back-to-back lookups of one thread, then interleaved threads
    cur_req = "R8"; q.delete();
    for (int i = 0; i < 8; i++) begin look(pool[i % 6], 0); cyc(); end
    for (int i = 0; i < 8; i++) begin look(pool[i % 6], i % 2); cyc(); end
    idle(); cyc();

    // R9: repair coinciding with lookups of the same and the other thread
    cur_req = "R9"; q.delete();
    look(16'h3401, 0); cyc();
    look(16'h3401, 0); resolve_flip(); cyc();
    look(16'h3401, 1); resolve_flip(); cyc();
    look(16'h3401, 0); up_valid = 0; cyc();
    idle(); cyc();
    look(16'h0012, 1); cyc();
    idle(); resolve_flip(); cyc();
    look(16'h0012, 1); up_valid = 0; cyc();
    idle(); cyc();

    // R10: lookup right after an update, and updates hitting one entry
    cur_req = "R10"; q.delete();
    for (int i = 0; i < 4; i++) begin look(16'h5555, 0); cyc(); end
    idle(); resolve(1); cyc();
    resolve(1); look(16'h5555, 0); cyc();
    resolve(1); look(16'h5555, 0); cyc();
    resolve(1); look(16'h5555, 0); cyc();
    idle(); look(16'h5555, 0); cyc();
    idle(); cyc();

    // R2: dense random traffic
    cur_req = "R2"; q.delete();
    void'($urandom(7));
    for (int i = 0; i < 4000; i++) begin
      int pc; bit tk;
      pc = pool[$urandom % 6];
      if ($urandom % 4 != 0) look(pc, $urandom % 2); else lk_valid = 0;
      if (q.size() > 0 && $urandom % 3 != 0) begin
        tk = (q[0].pc[0]) ? ($urandom % 8 != 0) : ($urandom % 8 == 0);
        resolve(tk);
      end else up_valid = 0;
      cyc();
    end
    idle(); cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule